// File: doc/BRIEF.md
# PPS-Synchronised Seconds/Ticks Timekeeper

This block holds the system time as two words: whole seconds and a sub-second tick count. The tick count advances on every clock and carries into the seconds word when it reaches a programmable ticks-per-second limit. Software sets the time through a small write-only register port of 32-bit words. It writes the seconds value first. The ticks value follows, and that second write completes the pair.

A completed pair is applied in one of two ways. In immediate mode it loads on the clock of the ticks write. In deferred mode it waits and loads on the next pulse-per-second (PPS) edge. The PPS signal is chosen from two inputs, and it can be taken on either its rising or its falling edge. At every selected PPS edge the block also keeps a copy of the running time. This lets software line up the local count with an external one-second reference.

Top module: `pps_timekeeper`

## Requirements
- R1: While reset is held, the seconds and ticks outputs and both PPS snapshot outputs are all zero.
- R2: On each clock without a load, ticks increase by one. When ticks are at or above ticks-per-second minus one, the next clock sets ticks to 0 and adds one to seconds. Seconds wrap modulo 2^32.
- R3: A write to address 4 sets the ticks-per-second limit, and the new limit governs later rollovers. The reset value is the parameter DEFAULT_TPS.
- R4: Address 3 bit 0 is the immediate flag, which resets to 0. While it is 1, a write to address 1 loads the time on that same clock: seconds come from the last address-0 write and ticks from the write data. The time then continues counting from the loaded value.
- R5: While the immediate flag is 0, a write to address 1 arms a pending load. The running time is not changed until the next selected PPS edge, which loads the pending seconds and ticks.
- R6: A selected PPS edge consumes the arm, so a later PPS edge does not load the same pair again.
- R7: Address 2 bit 0 selects the active PPS edge, with 0 meaning falling and 1 meaning rising. The reset value is 0. An edge of the other polarity neither loads nor snapshots.
- R8: Address 2 bit 1 selects the PPS source, with 0 meaning pps_ext and 1 meaning pps_alt. The reset value is 0. Edges on the unselected input have no effect.
- R9: At every selected PPS edge, whether or not a load is armed, pps_secs and pps_ticks capture the time as it was just before that edge's update.
- R10: PPS inputs pass through a two-flop synchroniser and then an edge detector. If an input changes before clock edge k, the load and snapshot happen at clock edge k+2, and no earlier.
- R11: A write to an unmapped address (5 to 7) does not change the running time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Word address of the register |
| cfg_wdata | input | 32 | Write data |
| pps_ext | input | 1 | PPS from the external connector |
| pps_alt | input | 1 | PPS from the alternate sync input |
| now_secs | output | 32 | Current seconds |
| now_ticks | output | 32 | Current ticks, from the same cycle as now_secs |
| pps_secs | output | 32 | Seconds captured at the last selected PPS edge |
| pps_ticks | output | 32 | Ticks captured at the last selected PPS edge |

## Verification
The bench builds the block with DEFAULT_TPS set to 20 and at one point reprograms it to 7. With these values a seconds rollover happens within a few dozen clocks, so random loads followed by random waits cross the carry boundary often. A directed load of all-ones seconds at the last tick checks the seconds wrap. The same small values keep the PPS scenarios short. These scenarios cover the two-cycle synchroniser delay, the opposite-polarity and unselected-source edges, and the second edge after an arm has been consumed.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned TK_ADDR_W = 3;
  localparam int unsigned TK_DATA_W = 32;

  typedef enum logic [TK_ADDR_W-1:0] {
    TK_A_SECS  = 3'd0,
    TK_A_TICKS = 3'd1,
    TK_A_FLAGS = 3'd2,
    TK_A_IMM   = 3'd3,
    TK_A_TPS   = 3'd4
  } tk_addr_e;
endpackage

// File: rtl/tk_pps_detect.sv
module tk_pps_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_ext,
  input  logic pps_alt,
  input  logic src_alt,
  input  logic edge_rise,
  output logic pps_edge
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic             raw;
  logic [LAST:0]    sync_q, sync_d;
  logic             hist_q, hist_d;

  assign raw = src_alt ? pps_alt : pps_ext;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], raw};
    hist_d = sync_q[LAST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  always_comb begin
    if (edge_rise) pps_edge = sync_q[LAST] & ~hist_q;
    else           pps_edge = ~sync_q[LAST] & hist_q;
  end

  AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    pps_edge |=> (!pps_edge || !$stable(edge_rise) || !$stable(src_alt))); // R7
endmodule

// File: rtl/tk_cfg_regs.sv
module tk_cfg_regs
  import tk_pkg::*;
#(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned DEFAULT_TPS = 100_000_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [TK_ADDR_W-1:0] addr,
  input  logic [TK_DATA_W-1:0] wdata,
  input  logic                 pps_edge,
  output logic                 edge_rise,
  output logic                 src_alt,
  output logic [TICK_W-1:0]    tps,
  output logic                 ld_en,
  output logic [SEC_W-1:0]     ld_secs,
  output logic [TICK_W-1:0]    ld_ticks
);
  logic [SEC_W-1:0]  pend_secs_q, pend_secs_d;
  logic [TICK_W-1:0] pend_ticks_q, pend_ticks_d;
  logic [TICK_W-1:0] tps_q, tps_d;
  logic              rise_q, rise_d, alt_q, alt_d, imm_q, imm_d;
  logic              armed_q, armed_d;
  logic              wr_secs, wr_ticks, wr_flags, wr_imm, wr_tps;
  logic              load_imm, load_pps;

  assign wr_secs  = we && (addr == TK_A_SECS);
  assign wr_ticks = we && (addr == TK_A_TICKS);
  assign wr_flags = we && (addr == TK_A_FLAGS);
  assign wr_imm   = we && (addr == TK_A_IMM);
  assign wr_tps   = we && (addr == TK_A_TPS);

  always_comb begin
    pend_secs_d  = pend_secs_q;
    pend_ticks_d = pend_ticks_q;
    tps_d        = tps_q;
    rise_d       = rise_q;
    alt_d        = alt_q;
    imm_d        = imm_q;
    armed_d      = armed_q;
    if (wr_secs)  pend_secs_d  = wdata[SEC_W-1:0];
    if (wr_ticks) pend_ticks_d = wdata[TICK_W-1:0];
    if (wr_tps)   tps_d        = wdata[TICK_W-1:0];
    if (wr_imm)   imm_d        = wdata[0];
    if (wr_flags) begin
      rise_d = wdata[0];
      alt_d  = wdata[1];
    end
    if (wr_ticks)      armed_d = ~imm_q;
    else if (pps_edge) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_secs_q  <= '0;
      pend_ticks_q <= '0;
      tps_q        <= TICK_W'(DEFAULT_TPS);
      rise_q       <= 1'b0;
      alt_q        <= 1'b0;
      imm_q        <= 1'b0;
      armed_q      <= 1'b0;
    end else begin
      pend_secs_q  <= pend_secs_d;
      pend_ticks_q <= pend_ticks_d;
      tps_q        <= tps_d;
      rise_q       <= rise_d;
      alt_q        <= alt_d;
      imm_q        <= imm_d;
      armed_q      <= armed_d;
    end
  end

  assign load_imm  = wr_ticks & imm_q;
  assign load_pps  = armed_q & pps_edge & ~wr_ticks;
  assign ld_en     = load_imm | load_pps;
  assign ld_secs   = pend_secs_q;
  assign ld_ticks  = load_imm ? wdata[TICK_W-1:0] : pend_ticks_q;
  assign edge_rise = rise_q;
  assign src_alt   = alt_q;
  assign tps       = tps_q;

  AST_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pps_edge && !wr_ticks) |=> !armed_q); // R6
  AST_IMM_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ticks && imm_q) |=> !armed_q); // R4
  AST_DEFER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ticks && !imm_q) |=> armed_q); // R5
endmodule

// File: rtl/tk_time_core.sv
module tk_time_core #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tps,
  input  logic              ld_en,
  input  logic [SEC_W-1:0]  ld_secs,
  input  logic [TICK_W-1:0] ld_ticks,
  input  logic              pps_edge,
  output logic [SEC_W-1:0]  secs,
  output logic [TICK_W-1:0] ticks,
  output logic [SEC_W-1:0]  snap_secs,
  output logic [TICK_W-1:0] snap_ticks
);
  logic [SEC_W-1:0]  secs_q, secs_d, snap_secs_q, snap_secs_d;
  logic [TICK_W-1:0] ticks_q, ticks_d, snap_ticks_q, snap_ticks_d;
  logic [TICK_W-1:0] tps_m1;
  logic              wrap;

  assign tps_m1 = tps - TICK_W'(1);
  assign wrap   = (ticks_q >= tps_m1);

  always_comb begin
    secs_d       = secs_q;
    ticks_d      = ticks_q;
    snap_secs_d  = snap_secs_q;
    snap_ticks_d = snap_ticks_q;
    if (ld_en) begin
      secs_d  = ld_secs;
      ticks_d = ld_ticks;
    end else if (wrap) begin
      secs_d  = secs_q + SEC_W'(1);
      ticks_d = '0;
    end else begin
      ticks_d = ticks_q + TICK_W'(1);
    end
    if (pps_edge) begin
      snap_secs_d  = secs_q;
      snap_ticks_d = ticks_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q       <= '0;
      ticks_q      <= '0;
      snap_secs_q  <= '0;
      snap_ticks_q <= '0;
    end else begin
      secs_q       <= secs_d;
      ticks_q      <= ticks_d;
      snap_secs_q  <= snap_secs_d;
      snap_ticks_q <= snap_ticks_d;
    end
  end

  assign secs       = secs_q;
  assign ticks      = ticks_q;
  assign snap_secs  = snap_secs_q;
  assign snap_ticks = snap_ticks_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && ticks_q < tps_m1) |=> (ticks_q == $past(ticks_q) + TICK_W'(1) && secs_q == $past(secs_q))); // R2
  AST_ROLLOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && ticks_q >= tps_m1) |=> (ticks_q == '0 && secs_q == $past(secs_q) + SEC_W'(1))); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ticks_q == $past(ld_ticks) && secs_q == $past(ld_secs))); // R4
  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pps_edge |=> (snap_ticks_q == $past(ticks_q) && snap_secs_q == $past(secs_q))); // R9
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pps_edge |=> $stable(snap_ticks_q)); // R7
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
  import tk_pkg::*;
#(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned DEFAULT_TPS = 100_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [TK_ADDR_W-1:0] cfg_addr,
  input  logic [TK_DATA_W-1:0] cfg_wdata,
  input  logic                 pps_ext,
  input  logic                 pps_alt,
  output logic [SEC_W-1:0]     now_secs,
  output logic [TICK_W-1:0]    now_ticks,
  output logic [SEC_W-1:0]     pps_secs,
  output logic [TICK_W-1:0]    pps_ticks
);
  logic              pps_edge, edge_rise, src_alt, ld_en;
  logic [TICK_W-1:0] tps, ld_ticks;
  logic [SEC_W-1:0]  ld_secs;

  tk_pps_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps_ext   (pps_ext),
    .pps_alt   (pps_alt),
    .src_alt   (src_alt),
    .edge_rise (edge_rise),
    .pps_edge  (pps_edge)
  );

  tk_cfg_regs #(.SEC_W(SEC_W), .TICK_W(TICK_W), .DEFAULT_TPS(DEFAULT_TPS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .pps_edge  (pps_edge),
    .edge_rise (edge_rise),
    .src_alt   (src_alt),
    .tps       (tps),
    .ld_en     (ld_en),
    .ld_secs   (ld_secs),
    .ld_ticks  (ld_ticks)
  );

  tk_time_core #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tps        (tps),
    .ld_en      (ld_en),
    .ld_secs    (ld_secs),
    .ld_ticks   (ld_ticks),
    .pps_edge   (pps_edge),
    .secs       (now_secs),
    .ticks      (now_ticks),
    .snap_secs  (pps_secs),
    .snap_ticks (pps_ticks)
  );

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (now_secs == '0 && now_ticks == '0 && pps_secs == '0 && pps_ticks == '0)); // R1
endmodule

// File: tb/tb_pps_timekeeper.sv
module tb_pps_timekeeper;
  localparam int unsigned TPS0 = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pps_ext = 1'b0;
  logic        pps_alt = 1'b0;
  logic [31:0] now_secs, now_ticks, pps_secs, pps_ticks;

  always #10 clk = ~clk;

  pps_timekeeper #(.DEFAULT_TPS(TPS0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pps_ext(pps_ext), .pps_alt(pps_alt),
    .now_secs(now_secs), .now_ticks(now_ticks),
    .pps_secs(pps_secs), .pps_ticks(pps_ticks)
  );

  int unsigned checks = 0, errors = 0;
  bit          done = 1'b0;

  // bench model of the required behaviour
  logic [31:0] ms, mt, msn_s, msn_t, mtps, mpend_s, mpend_t, ld_s, ld_t;
  bit          mimm, marmed, mrise, malt, ld_req, ev_fire;
  int          cd;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_now(string req);
    chk(req, "now_secs", now_secs, ms);
    chk(req, "now_ticks", now_ticks, mt);
  endtask

  task automatic chk_snap(string req);
    chk(req, "pps_secs", pps_secs, msn_s);
    chk(req, "pps_ticks", pps_ticks, msn_t);
  endtask

  function automatic void adv1();
    if (mt >= mtps - 32'd1) begin
      mt = 0;
      ms = ms + 32'd1;
    end else mt = mt + 32'd1;
  endfunction

  task automatic cyc();
    @(negedge clk);
    if (ld_req) begin
      ms = ld_s; mt = ld_t; ld_req = 1'b0;
    end else if (cd == 1 && ev_fire) begin
      msn_s = ms; msn_t = mt;
      if (marmed) begin
        ms = mpend_s; mt = mpend_t; marmed = 1'b0;
      end else adv1();
    end else adv1();
    if (cd > 0) cd--;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    case (a)
      3'd0: mpend_s = d;
      3'd1: begin
        if (mimm) begin
          ld_req = 1'b1; ld_s = mpend_s; ld_t = d; marmed = 1'b0;
        end else begin
          mpend_t = d; marmed = 1'b1;
        end
      end
      3'd2: begin mrise = d[0]; malt = d[1]; end
      3'd3: mimm = d[0];
      3'd4: mtps = d;
      default: ;
    endcase
    cyc();
    cfg_we = 1'b0;
  endtask

  task automatic pps(bit alt, bit val);
    bit old;
    old = alt ? pps_alt : pps_ext;
    if (alt) pps_alt = val; else pps_ext = val;
    ev_fire = (alt == malt) && (old != val) && (val == mrise);
    cd = 3;
  endtask

  task automatic arm(logic [31:0] s, logic [31:0] t);
    wr(3'd0, s);
    wr(3'd1, t);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, t;
    ms = 0; mt = 0; msn_s = 0; msn_t = 0; mtps = TPS0; mpend_s = 0; mpend_t = 0;
    mimm = 0; marmed = 0; mrise = 0; malt = 0; ld_req = 0; ev_fire = 0; cd = 0;
    ld_s = 0; ld_t = 0;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    chk_now("R1");
    chk_snap("R1");
    rst_n = 1'b1;
    cyc();
    chk("R2", "first tick", now_ticks, 32'd1);
    repeat (25) cyc();
    chk_now("R2");

    // immediate loads with random values and waits
    wr(3'd3, 32'd1);
    for (int i = 0; i < 12; i++) begin
      s = $urandom;
      t = $urandom % TPS0;
      arm(s, t);
      chk_now("R4");
      chk("R4", "loaded ticks", now_ticks, t);
      repeat ($urandom % 50) cyc();
      chk_now("R2");
    end

    // seconds wrap at the last tick
    arm(32'hFFFF_FFFF, TPS0 - 1);
    chk_now("R4");
    cyc();
    chk("R2", "secs wrap", now_secs, 32'd0);
    chk("R2", "ticks wrap", now_ticks, 32'd0);

    // reprogrammed ticks-per-second
    wr(3'd4, 32'd7);
    arm(32'd100, 32'd5);
    repeat (3) cyc();
    chk("R3", "secs after short roll", now_secs, 32'd101);
    chk("R3", "ticks after short roll", now_ticks, 32'd1);
    repeat (10) cyc();
    chk_now("R3");
    wr(3'd4, TPS0);

    // unmapped address
    wr(3'd6, 32'h5555_5555);
    chk_now("R11");
    repeat (5) cyc();
    chk_now("R11");

    // deferred load, rising edge, external source
    wr(3'd3, 32'd0);
    wr(3'd2, 32'd1);
    s = $urandom; t = $urandom % TPS0;
    arm(s, t);
    repeat (4) cyc();
    chk_now("R5");
    pps(1'b0, 1'b1);
    cyc(); cyc();
    chk_now("R10");
    cyc();
    chk_now("R5");
    chk("R5", "deferred ticks", now_ticks, t);
    chk("R5", "deferred secs", now_secs, s);
    chk_snap("R9");
    repeat (3) cyc();
    pps(1'b0, 1'b0);
    repeat (3) cyc();
    chk_snap("R7");
    chk_now("R7");
    repeat (2) cyc();
    pps(1'b0, 1'b1);
    repeat (3) cyc();
    chk_now("R6");
    chk_snap("R9");
    pps(1'b0, 1'b0);
    repeat (3) cyc();

    // falling edge polarity
    wr(3'd2, 32'd0);
    s = $urandom; t = $urandom % TPS0;
    arm(s, t);
    pps(1'b0, 1'b1);
    repeat (3) cyc();
    chk_now("R7");
    pps(1'b0, 1'b0);
    repeat (3) cyc();
    chk_now("R7");
    chk("R7", "falling-edge load ticks", now_ticks, t);
    chk_snap("R9");

    // alternate source, rising edge
    wr(3'd2, 32'd3);
    s = $urandom; t = $urandom % TPS0;
    arm(s, t);
    pps(1'b0, 1'b1);
    repeat (3) cyc();
    chk_now("R8");
    pps(1'b0, 1'b0);
    repeat (3) cyc();
    pps(1'b1, 1'b1);
    repeat (3) cyc();
    chk_now("R8");
    chk("R8", "alt load secs", now_secs, s);
    chk_snap("R8");
    pps(1'b1, 1'b0);
    repeat (3) cyc();
    chk_now("R8");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule